// File: doc/BRIEF.md
# Transmit Character Flow Controller

This block chooses, once per character slot, which character the serial transmit path receives next. The character can be host data taken through a one-entry input register, a character read from an external transmit FIFO, a pattern word from a built-in self-test generator, or a link-synchronisation fill command. The FIFO is a first-word-fall-through type: its read data is valid whenever it is not empty. When there is nothing to send, the block emits a two-character fill command. In ten-bit character mode this command is the J/K pair; in eight-bit mode it is the L/M pair. A tag bit marks every slot as data or command, so a downstream encoder can pick the right code space.

A mode input selects FIFO operation or bypass operation. In bypass, a host character moves from the input register straight into the output pipeline register. In FIFO operation, the block strobes a read for each character it takes. A halt input gives back-pressure on FIFO reads at a character boundary. Halt has no effect in bypass. When the encoder is bypassed, an inject flag goes with each fill character, so the fill goes straight into the shifter slot.

Top module: `txflow_ctrl`

## Requirements
- R1: While `rst_n` is low, `out_char`, `out_is_cmd`, `out_inject` and `fifo_rd` are all 0.
- R2: With `fifo_mode`=0, a character offered with `host_wr_en`=1 and `host_full`=0 at a clock edge is loaded into the input register. It appears on `out_char` with `out_is_cmd`=0 at the first later edge that is not taken by the second half of a fill pair. An offer with `host_full`=1 is not loaded.
- R3: A slot with nothing to send emits fill with `out_is_cmd`=1: FILL_J then FILL_K when `char10`=1, and FILL_L then FILL_M when `char10`=0. The second half always takes the very next slot, whatever data, halt or test input is present. Its code and inject flag are fixed when the first half is chosen.
- R4: In bypass, a write offered while the input register still holds an unsent character is not loaded.
- R5: With `fifo_mode`=1 and `halt`=1, `fifo_rd` stays 0 and the slot carries fill. With `fifo_mode`=0, `halt` has no effect.
- R6: With `fifo_mode`=1, `fifo_empty`=0, `halt`=0, `bist_en`=0 and no fill half pending, `fifo_rd` is 1 in that same cycle. `fifo_rdata` then appears on `out_char` with `out_is_cmd`=0 after the next edge. There is one read per slot and no read in a fill slot.
- R7: `out_inject` equals `enc_bypass` for a first fill half and repeats that value for the second half. It is 0 for data and test characters.
- R8: While `bist_en`=1 and no fill half is pending, `fifo_rd` is 0 and `out_char` carries the low W bits of a 16-bit LFSR, with `out_is_cmd`=0. The LFSR uses seed 0xACE1, shifts left, and feeds bit 0 with bit15^bit13^bit12^bit10. The emitted value is the state before the advance. The state advances only in slots that emit a test character and returns to the seed while `bist_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | 1 = FIFO source, 0 = bypass through input register |
| enc_bypass | input | 1 | 1 = encoder bypassed, fill goes straight to shifter slot |
| char10 | input | 1 | 1 = ten-bit mode (J/K fill), 0 = eight-bit mode (L/M fill) |
| host_wr_en | input | 1 | Host write enable (bypass) |
| host_full | input | 1 | Host full flag, blocks loading when 1 |
| host_data | input | W | Host character |
| fifo_empty | input | 1 | Transmit FIFO empty |
| fifo_rdata | input | W | FIFO head character |
| fifo_rd | output | 1 | FIFO read strobe for this slot |
| halt | input | 1 | FIFO read back-pressure |
| bist_en | input | 1 | Select test-pattern source |
| out_char | output | W | Character for this slot |
| out_is_cmd | output | 1 | 1 = command (fill) character |
| out_inject | output | 1 | 1 = fill goes straight into the shifter slot |

## Verification
The bench targets the fill pair boundary. It asserts halt, switches to test mode and changes the mode inputs exactly in the second-half slot. A design that re-decides that slot would split the pair, emit a mixed J/M pair, or drop the inject flag. It writes into the input register while it still holds a character: a design without the hold would overwrite the first character and send the second. It also checks that halt stops a FIFO read in the same slot but does nothing in bypass, and that test mode suppresses reads and restarts its pattern from the seed.

// File: rtl/txflow_pkg.sv
package txflow_pkg;
   typedef enum logic [1:0] {
      SRC_FILL1 = 2'd0,
      SRC_FILL2 = 2'd1,
      SRC_DATA  = 2'd2,
      SRC_BIST  = 2'd3
   } src_e;

   typedef struct packed {
      logic c10;
      logic inj;
   } pair_ctx_t;
endpackage

// File: rtl/txflow_inreg.sv
module txflow_inreg #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         enable,
   input  logic         wr_en,
   input  logic         full,
   input  logic [W-1:0] din,
   input  logic         consume,
   output logic         vld,
   output logic [W-1:0] dat
);
   logic load;
   logic busy;

   assign busy = vld & ~consume;
   assign load = enable & wr_en & ~full & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= 1'b0;
         dat <= '0;
      end else if (!enable) begin
         vld <= 1'b0;
      end else begin
         vld <= load | busy;
         if (load) dat <= din;
      end
   end

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && vld && !consume) |=> (vld && $stable(dat)));
endmodule

// File: rtl/txflow_lfsr.sv
module txflow_lfsr #(
   parameter int              W      = 10,
   parameter int              LW     = 16,
   parameter logic [LW-1:0]   TAPS   = 16'hB400,
   parameter logic [LW-1:0]   SEED   = 16'hACE1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         step,
   output logic [W-1:0] pat
);
   logic [LW-1:0] st;
   logic          fb;

   assign fb  = ^(st & TAPS);
   assign pat = st[W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      st <= SEED;
      else if (!run)   st <= SEED;
      else if (step)   st <= {st[LW-2:0], fb};
   end

   assert_seed_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (st == SEED));
endmodule

// File: rtl/txflow_arb.sv
module txflow_arb
   import txflow_pkg::*;
#(
   parameter int          W       = 10,
   parameter bit          BIST_ON = 1'b1,
   parameter logic [W-1:0] FILL_J = 10'h3C1,
   parameter logic [W-1:0] FILL_K = 10'h2E4,
   parameter logic [W-1:0] FILL_L = 10'h0F8,
   parameter logic [W-1:0] FILL_M = 10'h1B6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fifo_mode,
   input  logic         enc_bypass,
   input  logic         char10,
   input  logic         fifo_empty,
   input  logic         halt,
   input  logic         bist_en,
   input  logic         in_vld,
   output src_e         src,
   output logic [W-1:0] fill_code,
   output logic         fill_inj,
   output logic         rd_sel,
   output logic         consume,
   output logic         step
);
   logic      pend;
   pair_ctx_t ctx;

   always_comb begin
      if (pend)                          src = SRC_FILL2;
      else if (BIST_ON && bist_en)       src = SRC_BIST;
      else if (fifo_mode)                src = (!fifo_empty && !halt) ? SRC_DATA : SRC_FILL1;
      else                               src = in_vld ? SRC_DATA : SRC_FILL1;
   end

   always_comb begin
      fill_code = '0;
      fill_inj  = 1'b0;
      case (src)
         SRC_FILL1: begin
            fill_code = char10 ? FILL_J : FILL_L;
            fill_inj  = enc_bypass;
         end
         SRC_FILL2: begin
            fill_code = ctx.c10 ? FILL_K : FILL_M;
            fill_inj  = ctx.inj;
         end
         default: ;
      endcase
   end

   assign rd_sel  = (src == SRC_DATA) &  fifo_mode;
   assign consume = (src == SRC_DATA) & ~fifo_mode;
   assign step    = (src == SRC_BIST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         ctx  <= '0;
      end else begin
         pend <= (src == SRC_FILL1);
         if (src == SRC_FILL1) begin
            ctx.c10 <= char10;
            ctx.inj <= enc_bypass;
         end
      end
   end

   assert_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_mode && halt) |-> !rd_sel);
   assert_bist_noread_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (BIST_ON && bist_en) |-> !rd_sel);
   assert_pair_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_FILL1) |=> (src == SRC_FILL2));
endmodule

// File: rtl/txflow_ctrl.sv
module txflow_ctrl
   import txflow_pkg::*;
#(
   parameter int             W       = 10,
   parameter bit             BIST_ON = 1'b1,
   parameter int             LFSR_W  = 16,
   parameter logic [15:0]    TAPS    = 16'hB400,
   parameter logic [15:0]    SEED    = 16'hACE1,
   parameter logic [W-1:0]   FILL_J  = 10'h3C1,
   parameter logic [W-1:0]   FILL_K  = 10'h2E4,
   parameter logic [W-1:0]   FILL_L  = 10'h0F8,
   parameter logic [W-1:0]   FILL_M  = 10'h1B6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fifo_mode,
   input  logic         enc_bypass,
   input  logic         char10,
   input  logic         host_wr_en,
   input  logic         host_full,
   input  logic [W-1:0] host_data,
   input  logic         fifo_empty,
   input  logic [W-1:0] fifo_rdata,
   output logic         fifo_rd,
   input  logic         halt,
   input  logic         bist_en,
   output logic [W-1:0] out_char,
   output logic         out_is_cmd,
   output logic         out_inject
);
   if (W > LFSR_W) begin : g_bad_width
      $error("txflow_ctrl: W must not exceed LFSR_W");
   end
   if (FILL_J == FILL_K || FILL_L == FILL_M || FILL_J == FILL_M || FILL_L == FILL_K) begin : g_bad_fill
      $error("txflow_ctrl: fill codes must be distinct");
   end

   src_e         src;
   logic [W-1:0] fill_code;
   logic         fill_inj;
   logic         rd_sel;
   logic         consume;
   logic         step;
   logic         in_vld;
   logic [W-1:0] in_dat;
   logic [W-1:0] pat;
   logic [W-1:0] nxt_char;

   txflow_inreg #(.W(W)) u_inreg (
      .clk(clk), .rst_n(rst_n), .enable(~fifo_mode),
      .wr_en(host_wr_en), .full(host_full), .din(host_data),
      .consume(consume), .vld(in_vld), .dat(in_dat)
   );

   txflow_arb #(
      .W(W), .BIST_ON(BIST_ON),
      .FILL_J(FILL_J), .FILL_K(FILL_K), .FILL_L(FILL_L), .FILL_M(FILL_M)
   ) u_arb (
      .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .enc_bypass(enc_bypass),
      .char10(char10), .fifo_empty(fifo_empty), .halt(halt), .bist_en(bist_en),
      .in_vld(in_vld), .src(src), .fill_code(fill_code), .fill_inj(fill_inj),
      .rd_sel(rd_sel), .consume(consume), .step(step)
   );

   if (BIST_ON) begin : g_bist
      txflow_lfsr #(
         .W(W), .LW(LFSR_W), .TAPS(TAPS[LFSR_W-1:0]), .SEED(SEED[LFSR_W-1:0])
      ) u_lfsr (
         .clk(clk), .rst_n(rst_n), .run(bist_en), .step(step), .pat(pat)
      );
   end else begin : g_nobist
      assign pat = '0;
   end

   always_comb begin
      case (src)
         SRC_DATA: nxt_char = fifo_mode ? fifo_rdata : in_dat;
         SRC_BIST: nxt_char = pat;
         default:  nxt_char = fill_code;
      endcase
   end

   assign fifo_rd = rd_sel & rst_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_char   <= '0;
         out_is_cmd <= 1'b0;
         out_inject <= 1'b0;
      end else begin
         out_char   <= nxt_char;
         out_is_cmd <= (src == SRC_FILL1) || (src == SRC_FILL2);
         out_inject <= fill_inj;
      end
   end

   assert_read_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd |=> !out_is_cmd);
   assert_read_char_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd |=> (out_char == $past(fifo_rdata)));
   assert_inject_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_inject |-> out_is_cmd);
   assert_pair_jk_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_is_cmd && out_char == FILL_J) |=> (out_is_cmd && out_char == FILL_K));
   assert_pair_lm_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_is_cmd && out_char == FILL_L) |=> (out_is_cmd && out_char == FILL_M));
   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |-> (!fifo_rd && !out_is_cmd && !out_inject && out_char == '0));
endmodule

// File: tb/tb_txflow_ctrl.sv
module tb_txflow_ctrl;
   localparam int W = 10;
   localparam logic [W-1:0] FJ = 10'h3C1;
   localparam logic [W-1:0] FK = 10'h2E4;
   localparam logic [W-1:0] FL = 10'h0F8;
   localparam logic [W-1:0] FM = 10'h1B6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fifo_mode = 1'b1, enc_bypass = 1'b0, char10 = 1'b1;
   logic host_wr_en = 1'b0, host_full = 1'b0;
   logic [W-1:0] host_data = '0;
   logic fifo_empty = 1'b0;
   logic [W-1:0] fifo_rdata = '0;
   logic fifo_rd, halt = 1'b0, bist_en = 1'b0;
   logic [W-1:0] out_char;
   logic out_is_cmd, out_inject;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   txflow_ctrl dut (
      .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .enc_bypass(enc_bypass),
      .char10(char10), .host_wr_en(host_wr_en), .host_full(host_full),
      .host_data(host_data), .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata),
      .fifo_rd(fifo_rd), .halt(halt), .bist_en(bist_en), .out_char(out_char),
      .out_is_cmd(out_is_cmd), .out_inject(out_inject)
   );

   typedef struct packed {
      logic         bist;
      logic         mode;
      logic         enb;
      logic         c10;
      logic         empty;
      logic         hlt;
      logic [W-1:0] rdata;
      logic         erd;
      logic         ecmd;
      logic         einj;
      logic [W-1:0] echar;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,10'h055, 1'b1,1'b0,1'b0,10'h055},
      '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,10'h1FF, 1'b1,1'b0,1'b0,10'h1FF},
      '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,10'h000, 1'b0,1'b1,1'b0,FJ},
      '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,10'h0AA, 1'b0,1'b1,1'b0,FK},
      '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,10'h0AA, 1'b0,1'b1,1'b0,FL},
      '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,10'h0AA, 1'b0,1'b1,1'b0,FM},
      '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,10'h0AA, 1'b1,1'b0,1'b0,10'h0AA},
      '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,10'h000, 1'b0,1'b1,1'b1,FJ},
      '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,10'h000, 1'b0,1'b1,1'b1,FK},
      '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,10'h300, 1'b1,1'b0,1'b0,10'h300},
      '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,10'h000, 1'b0,1'b1,1'b0,FJ},
      '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,10'h000, 1'b0,1'b1,1'b0,FK},
      '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,10'h000, 1'b0,1'b0,1'b0,10'h0E1},
      '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,10'h123, 1'b1,1'b0,1'b0,10'h123}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic slot_out(input string req, input logic [W-1:0] ec, input logic ecmd, input logic einj);
      @(posedge clk);
      @(negedge clk);
      chk(req, {21'd0, einj ^ out_inject, out_char}, {21'd0, 1'b0, ec});
      chk(req, {31'd0, out_is_cmd}, {31'd0, ecmd});
   endtask

   function automatic logic [15:0] lfsr_next(input logic [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] s;
      repeat (3) @(negedge clk);
      // R1: outputs idle in reset even with a readable FIFO
      chk("R1 fifo_rd", {31'd0, fifo_rd}, 32'd0);
      chk("R1 out", {20'd0, out_is_cmd, out_inject, out_char}, 32'd0);
      rst_n = 1'b1;

      // table walk: FIFO mode, halt, fill pairs, inject, test pattern (R3 R5 R6 R7 R8)
      for (int i = 0; i < NV; i++) begin
         bist_en    = VEC[i].bist;
         fifo_mode  = VEC[i].mode;
         enc_bypass = VEC[i].enb;
         char10     = VEC[i].c10;
         fifo_empty = VEC[i].empty;
         halt       = VEC[i].hlt;
         fifo_rdata = VEC[i].rdata;
         #1;
         chk("R6 read strobe", {31'd0, fifo_rd}, {31'd0, VEC[i].erd});
         @(posedge clk);
         @(negedge clk);
         chk("R3 R6 char", {22'd0, out_char}, {22'd0, VEC[i].echar});
         chk("R3 cmd tag", {31'd0, out_is_cmd}, {31'd0, VEC[i].ecmd});
         chk("R7 inject", {31'd0, out_inject}, {31'd0, VEC[i].einj});
      end

      // bypass with halt held high: halt must be ignored (R5)
      fifo_mode = 1'b0; halt = 1'b1; char10 = 1'b1; enc_bypass = 1'b0;
      host_wr_en = 1'b0; host_full = 1'b0;
      slot_out("R3 bypass fill first", FJ, 1'b1, 1'b0);
      host_wr_en = 1'b1; host_data = 10'h011;
      slot_out("R3 second half", FK, 1'b1, 1'b0);
      host_data = 10'h022;
      slot_out("R2 R5 bypass data", 10'h011, 1'b0, 1'b0);
      host_data = 10'h033; host_full = 1'b1;
      slot_out("R2 bypass data", 10'h022, 1'b0, 1'b0);
      host_wr_en = 1'b0; host_full = 1'b0;
      slot_out("R2 full blocks load", FJ, 1'b1, 1'b0);
      slot_out("R3 second half", FK, 1'b1, 1'b0);
      host_wr_en = 1'b1; host_data = 10'h044;
      slot_out("R3 fill while loading", FJ, 1'b1, 1'b0);
      host_data = 10'h055;
      slot_out("R4 pair kept", FK, 1'b1, 1'b0);
      host_wr_en = 1'b0;
      slot_out("R4 held char", 10'h044, 1'b0, 1'b0);
      slot_out("R4 overlapped write dropped", FJ, 1'b1, 1'b0);

      // back to FIFO mode, then test pattern sequence (R8)
      fifo_mode = 1'b1; halt = 1'b0; fifo_empty = 1'b0; fifo_rdata = 10'h100;
      slot_out("R3 second half", FK, 1'b1, 1'b0);
      slot_out("R6 fifo data", 10'h100, 1'b0, 1'b0);
      bist_en = 1'b1;
      #1;
      chk("R8 no read in test", {31'd0, fifo_rd}, 32'd0);
      s = 16'hACE1;
      for (int k = 0; k < 4; k++) begin
         slot_out("R8 pattern", s[W-1:0], 1'b0, 1'b0);
         s = lfsr_next(s);
      end
      bist_en = 1'b0;
      slot_out("R8 leaves test", 10'h100, 1'b0, 1'b0);
      bist_en = 1'b1;
      slot_out("R8 reseeded", 10'h0E1, 1'b0, 1'b0);
      bist_en = 1'b0;

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule